// File: doc/BRIEF.md
# Banked Effective Address Generator

This block turns a 6-bit operand addressing-mode field, plus up to two 16-bit extension words that follow it in the instruction stream, into a 24-bit effective address. The low 16 bits come from pointer arithmetic on the eight 16-bit general registers or the program counter. The high 8 bits always come from one of six 8-bit bank registers, or from a literal byte carried in a bank extension word. Each general register has a home bank: registers 0 and 1 use bank 0, 2 and 3 use bank 1, 4 and 5 use bank 2, and 6 and 7 use bank 3. The program counter uses the program bank.

The block does not access memory. It classifies the operand in one of four ways: a memory address, a direct general register, an immediate literal, or a special register (a bank register or the status register). It reports how many extension words the mode consumed, so that the fetch logic can advance past them. For auto-increment and auto-decrement modes it also produces the pointer write-back. A request is presented with `req_valid`, and the complete result appears on registered outputs one clock later.

Top module: `banked_ea_gen`

## Requirements
- R1: A request presented with `req_valid` high before a rising edge yields `res_valid` high and its result on all outputs after that edge. When `req_valid` is low before an edge, `res_valid` is low after it and every other output keeps its previous value. Synchronous reset clears all outputs to zero.
- R2: Mode `000rrr` gives kind 1 (general register), `reg_sel`=rrr, 0 extension words, `ea`=0 and no write-back. Mode `111111` gives kind 2 (immediate) with 1 extension word. Kind encoding: 0 memory, 1 general register, 2 immediate, 3 special register. For every kind other than memory, `ea` is 0.
- R3: Mode `001rrr` gives a memory operand with `ea` = {home bank of rrr, R[rrr]}, where the home bank index is rrr>>1 (bank register i sits at `bank_flat[8*i+7:8*i]`, i=0..3; index 4 is the program bank and index 5 is the absolute bank). It uses 0 extension words.
- R4: Mode `010rrr` forms the address from the unmodified register and writes back R[rrr]+step, where step is 1 when `size_word`=0 and 2 when `size_word`=1. The write-back wraps modulo 2^16 and is reported on `wb_en`/`wb_reg`/`wb_data`.
- R5: Mode `011rrr` computes R[rrr]-step (mod 2^16) and uses it both as the address low half and as the write-back value.
- R6: Mode `100rrr` gives a low half of R[rrr] + ext0 (mod 2^16, never carrying into the bank byte) with the home bank, and 1 extension word.
- R7: A bank word carries a selector in bits 10..8 and a literal in bits 7..0. Selectors 0-3 pick banks 0-3, 4 picks the program bank, 5 picks the absolute bank, and 6 or 7 use the literal. Mode `101rrr` takes its bank word from ext0 (1 word). Mode `110rrr` takes its displacement from ext0 and its bank word from ext1 (2 words).
- R8: The absolute modes give ext0 as the low half. The high byte is the absolute bank for `111000`, the program bank for `111001` (both 1 word), and the bank word in ext1 for `111010` (2 words).
- R9: For mode `111011`, ext0 is an index word: first register in bits 15..13, second register in bits 12..10, scale in bit 9 (0 = x1, 1 = x2), and a 9-bit sign-extended displacement in bits 8..0. The low half is R1 + R2*scale + disp (mod 2^16), the bank is the first register's home bank, and the mode uses 1 word. Mode `111100` is the same but takes its bank from a bank word in ext1 (2 words).
- R10: Mode `111101` gives {program bank, PC+ext0}. Mode `111110` with ext0 bit 15 = 0 gives {program bank, PC + R2*scale + disp} using the index-word fields. Both use 1 word.
- R11: Mode `111110` with ext0 bit 15 = 1 gives kind 3 (special register) with `reg_sel` = ext0[12:10] (0-3 banks, 4 program bank, 5 absolute bank, 6 status). It returns `ea`=0, 1 extension word and no write-back, and bits 9..0 of ext0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe; inputs are captured when high |
| mode | input | 6 | Addressing-mode field |
| size_word | input | 1 | Operand size: 0 byte, 1 word |
| ext0 | input | 16 | First extension word |
| ext1 | input | 16 | Second extension word |
| gpr_flat | input | 128 | General registers, register i at bits 16*i+15..16*i |
| pc | input | 16 | Program counter low half |
| bank_flat | input | 48 | Bank registers, index i at bits 8*i+7..8*i |
| res_valid | output | 1 | Result valid |
| ea | output | 24 | Effective address |
| kind | output | 2 | Operand kind |
| reg_sel | output | 3 | Register number for register or special kinds |
| ext_count | output | 2 | Extension words consumed (0-2) |
| wb_en | output | 1 | Pointer write-back required |
| wb_reg | output | 3 | Register to write back |
| wb_data | output | 16 | Value to write back |

## Verification
Every result, the write-back included, sits behind a single output register, so it is due exactly one rising edge after the request. The bench changes inputs on a falling edge and compares all outputs at the next falling edge, away from the capture edge. Hold behaviour is checked by dropping the strobe while the inputs are changed, then confirming one falling edge later that nothing moved. The sweep covers all 64 modes at both sizes with varied register and extension contents.

// File: rtl/beag_pkg.sv
package beag_pkg;
    localparam int WORD_W     = 16;
    localparam int BANK_W     = 8;
    localparam int NUM_GPR    = 8;
    localparam int NUM_BANK   = 6;
    localparam int SEL_W      = 3;
    localparam int MODE_W     = 6;
    localparam int SDISP_W    = 9;
    localparam int EA_W       = WORD_W + BANK_W;
    localparam int GPR_FLAT_W = NUM_GPR * WORD_W;
    localparam int BNK_FLAT_W = NUM_BANK * BANK_W;

    localparam logic [SEL_W-1:0] BSEL_PROG = 3'd4;
    localparam logic [SEL_W-1:0] BSEL_ABS  = 3'd5;

    typedef enum logic [1:0] {
        OPK_MEM = 2'd0,
        OPK_GPR = 2'd1,
        OPK_IMM = 2'd2,
        OPK_SPR = 2'd3
    } opkind_e;

    typedef enum logic [1:0] { BASE_GPR, BASE_PC, BASE_ABS } base_e;
    typedef enum logic [1:0] { DISP_NONE, DISP_FULL, DISP_SHORT } disp_e;
    typedef enum logic [1:0] { BW_NONE, BW_EXT0, BW_EXT1 } bword_e;

    typedef struct packed {
        opkind_e          kind;
        logic [SEL_W-1:0] reg_sel;
        base_e            base;
        logic [SEL_W-1:0] base_reg;
        logic             use_index;
        disp_e            disp;
        bword_e           bword;
        logic [SEL_W-1:0] home_bank;
        logic             post_inc;
        logic             pre_dec;
        logic [1:0]       ext_count;
    } ea_ctrl_t;

    typedef struct packed {
        logic [EA_W-1:0]   ea;
        opkind_e           kind;
        logic [SEL_W-1:0]  reg_sel;
        logic [1:0]        ext_count;
        logic              wb_en;
        logic [SEL_W-1:0]  wb_reg;
        logic [WORD_W-1:0] wb_data;
    } ea_result_t;

    function automatic logic [SEL_W-1:0] home_of(input logic [SEL_W-1:0] r);
        return {1'b0, r[SEL_W-1:1]};
    endfunction

    function automatic logic [WORD_W-1:0] sext_short(input logic [SDISP_W-1:0] d);
        return {{(WORD_W-SDISP_W){d[SDISP_W-1]}}, d};
    endfunction
endpackage

// File: rtl/beag_decode.sv
module beag_decode
    import beag_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic [WORD_W-1:0] ext0,
    output ea_ctrl_t          ctrl
);
    logic [SEL_W-1:0] rrr;
    logic [SEL_W-1:0] idx_r1;
    assign rrr    = mode[SEL_W-1:0];
    assign idx_r1 = ext0[WORD_W-1 -: SEL_W];

    always_comb begin
        ctrl           = '0;
        ctrl.kind      = OPK_MEM;
        ctrl.base      = BASE_GPR;
        ctrl.disp      = DISP_NONE;
        ctrl.bword     = BW_NONE;
        ctrl.base_reg  = rrr;
        ctrl.home_bank = home_of(rrr);
        unique case (mode[MODE_W-1:SEL_W])
            3'd0: begin
                ctrl.kind    = OPK_GPR;
                ctrl.reg_sel = rrr;
            end
            3'd1: ;
            3'd2: ctrl.post_inc = 1'b1;
            3'd3: ctrl.pre_dec  = 1'b1;
            3'd4: begin
                ctrl.disp      = DISP_FULL;
                ctrl.ext_count = 2'd1;
            end
            3'd5: begin
                ctrl.bword     = BW_EXT0;
                ctrl.ext_count = 2'd1;
            end
            3'd6: begin
                ctrl.disp      = DISP_FULL;
                ctrl.bword     = BW_EXT1;
                ctrl.ext_count = 2'd2;
            end
            default: begin
                ctrl.ext_count = 2'd1;
                unique case (rrr)
                    3'd0: begin
                        ctrl.base      = BASE_ABS;
                        ctrl.home_bank = BSEL_ABS;
                    end
                    3'd1: begin
                        ctrl.base      = BASE_ABS;
                        ctrl.home_bank = BSEL_PROG;
                    end
                    3'd2: begin
                        ctrl.base      = BASE_ABS;
                        ctrl.bword     = BW_EXT1;
                        ctrl.ext_count = 2'd2;
                    end
                    3'd3, 3'd4: begin
                        ctrl.base_reg  = idx_r1;
                        ctrl.home_bank = home_of(idx_r1);
                        ctrl.use_index = 1'b1;
                        ctrl.disp      = DISP_SHORT;
                        if (rrr == 3'd4) begin
                            ctrl.bword     = BW_EXT1;
                            ctrl.ext_count = 2'd2;
                        end
                    end
                    3'd5: begin
                        ctrl.base      = BASE_PC;
                        ctrl.home_bank = BSEL_PROG;
                        ctrl.disp      = DISP_FULL;
                    end
                    3'd6: begin
                        if (ext0[WORD_W-1]) begin
                            ctrl.kind    = OPK_SPR;
                            ctrl.reg_sel = ext0[12:10];
                        end else begin
                            ctrl.base      = BASE_PC;
                            ctrl.home_bank = BSEL_PROG;
                            ctrl.use_index = 1'b1;
                            ctrl.disp      = DISP_SHORT;
                        end
                    end
                    default: ctrl.kind = OPK_IMM;
                endcase
            end
        endcase
    end
endmodule

// File: rtl/beag_bank_mux.sv
module beag_bank_mux
    import beag_pkg::*;
(
    input  logic [BNK_FLAT_W-1:0] bank_flat,
    input  logic [SEL_W-1:0]      sel,
    input  logic [BANK_W-1:0]     literal,
    output logic [BANK_W-1:0]     bank
);
    logic [BANK_W-1:0] banks [NUM_BANK];

    for (genvar i = 0; i < NUM_BANK; i++) begin : g_unpack
        assign banks[i] = bank_flat[i*BANK_W +: BANK_W];
    end

    always_comb begin
        bank = literal;
        for (int i = 0; i < NUM_BANK; i++) begin
            if (sel == SEL_W'(i)) bank = banks[i];
        end
    end
endmodule

// File: rtl/beag_offset.sv
module beag_offset
    import beag_pkg::*;
(
    input  logic [WORD_W-1:0] base,
    input  logic [WORD_W-1:0] index,
    input  logic              use_index,
    input  logic              scale2,
    input  logic [WORD_W-1:0] disp,
    output logic [WORD_W-1:0] low
);
    logic [WORD_W-1:0] scaled;
    always_comb begin
        if (!use_index)  scaled = '0;
        else if (scale2) scaled = {index[WORD_W-2:0], 1'b0};
        else             scaled = index;
        low = base + scaled + disp;
    end
endmodule

// File: rtl/banked_ea_gen.sv
module banked_ea_gen
    import beag_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [MODE_W-1:0]     mode,
    input  logic                  size_word,
    input  logic [WORD_W-1:0]     ext0,
    input  logic [WORD_W-1:0]     ext1,
    input  logic [GPR_FLAT_W-1:0] gpr_flat,
    input  logic [WORD_W-1:0]     pc,
    input  logic [BNK_FLAT_W-1:0] bank_flat,
    output logic                  res_valid,
    output logic [EA_W-1:0]       ea,
    output logic [1:0]            kind,
    output logic [SEL_W-1:0]      reg_sel,
    output logic [1:0]            ext_count,
    output logic                  wb_en,
    output logic [SEL_W-1:0]      wb_reg,
    output logic [WORD_W-1:0]     wb_data
);
    logic [WORD_W-1:0] gpr [NUM_GPR];
    for (genvar i = 0; i < NUM_GPR; i++) begin : g_gpr
        assign gpr[i] = gpr_flat[i*WORD_W +: WORD_W];
    end

    ea_ctrl_t ctrl;
    beag_decode u_dec (.mode(mode), .ext0(ext0), .ctrl(ctrl));

    logic [WORD_W-1:0] step, ptr, ptr_dec, base_val, disp_val, low;
    logic [WORD_W-1:0] bword;
    logic [SEL_W-1:0]  bsel;
    logic [BANK_W-1:0] bank;

    always_comb begin
        step    = size_word ? WORD_W'(2) : WORD_W'(1);
        ptr     = gpr[ctrl.base_reg];
        ptr_dec = ptr - step;
        unique case (ctrl.base)
            BASE_PC:  base_val = pc;
            BASE_ABS: base_val = ext0;
            default:  base_val = ctrl.pre_dec ? ptr_dec : ptr;
        endcase
        unique case (ctrl.disp)
            DISP_FULL:  disp_val = ext0;
            DISP_SHORT: disp_val = sext_short(ext0[SDISP_W-1:0]);
            default:    disp_val = '0;
        endcase
        bword = (ctrl.bword == BW_EXT1) ? ext1 : ext0;
        bsel  = (ctrl.bword == BW_NONE) ? ctrl.home_bank : bword[10:8];
    end

    beag_offset u_off (
        .base(base_val), .index(gpr[ext0[12:10]]), .use_index(ctrl.use_index),
        .scale2(ext0[9]), .disp(disp_val), .low(low)
    );

    beag_bank_mux u_bank (
        .bank_flat(bank_flat), .sel(bsel), .literal(bword[BANK_W-1:0]), .bank(bank)
    );

    ea_result_t nxt, res_q;
    always_comb begin
        nxt           = '0;
        nxt.kind      = ctrl.kind;
        nxt.reg_sel   = ctrl.reg_sel;
        nxt.ext_count = ctrl.ext_count;
        if (ctrl.kind == OPK_MEM) begin
            nxt.ea = {bank, low};
            if (ctrl.post_inc || ctrl.pre_dec) begin
                nxt.wb_en   = 1'b1;
                nxt.wb_reg  = ctrl.base_reg;
                nxt.wb_data = ctrl.post_inc ? (ptr + step) : ptr_dec;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_q     <= '0;
        end else begin
            res_valid <= req_valid;
            if (req_valid) res_q <= nxt;
        end
    end

    assign ea        = res_q.ea;
    assign kind      = res_q.kind;
    assign reg_sel   = res_q.reg_sel;
    assign ext_count = res_q.ext_count;
    assign wb_en     = res_q.wb_en;
    assign wb_reg    = res_q.wb_reg;
    assign wb_data   = res_q.wb_data;
endmodule

// File: rtl/banked_ea_gen_chk.sv
module banked_ea_gen_chk
    import beag_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              size_word,
    input logic              res_valid,
    input logic [EA_W-1:0]   ea,
    input logic [1:0]        kind,
    input logic [1:0]        ext_count,
    input logic              wb_en,
    input logic [WORD_W-1:0] wb_data
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> res_valid); // R1
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!res_valid && $stable(ea) && $stable(wb_data))); // R1
    AST_NONMEM_NO_ADDR: assert property (@(posedge clk) disable iff (rst)
        (res_valid && kind != 2'd0) |-> (ea == '0 && !wb_en)); // R2
    AST_IMM_ONE_WORD: assert property (@(posedge clk) disable iff (rst)
        (res_valid && kind == 2'd2) |-> ext_count == 2'd1); // R2
    AST_STEP_SIZE: assert property (@(posedge clk) disable iff (rst)
        (res_valid && wb_en) |->
            ((wb_data - ea[WORD_W-1:0]) == ($past(size_word) ? 16'd2 : 16'd1)
             || wb_data == ea[WORD_W-1:0])); // R4
    AST_EXT_BOUND: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> ext_count <= 2'd2); // R7
endmodule

bind banked_ea_gen banked_ea_gen_chk u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .size_word(size_word),
    .res_valid(res_valid), .ea(ea), .kind(kind), .ext_count(ext_count),
    .wb_en(wb_en), .wb_data(wb_data)
);

// File: tb/banked_ea_gen_test.sv
module banked_ea_gen_test;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic [5:0]   mode = '0;
    logic         size_word = 1'b0;
    logic [15:0]  ext0 = '0, ext1 = '0, pc = '0;
    logic [127:0] gpr_flat = '0;
    logic [47:0]  bank_flat = '0;
    logic         res_valid, wb_en;
    logic [23:0]  ea;
    logic [1:0]   kind, ext_count;
    logic [2:0]   reg_sel, wb_reg;
    logic [15:0]  wb_data;

    logic [15:0] regs [8];
    logic [7:0]  banks [6];
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    banked_ea_gen uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .mode(mode), .size_word(size_word),
        .ext0(ext0), .ext1(ext1), .gpr_flat(gpr_flat), .pc(pc), .bank_flat(bank_flat),
        .res_valid(res_valid), .ea(ea), .kind(kind), .reg_sel(reg_sel),
        .ext_count(ext_count), .wb_en(wb_en), .wb_reg(wb_reg), .wb_data(wb_data)
    );

    task automatic load_state();
        for (int i = 0; i < 8; i++) gpr_flat[i*16 +: 16] = regs[i];
        for (int i = 0; i < 6; i++) bank_flat[i*8 +: 8] = banks[i];
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (mode %b size %0d)", tag, act, exp, mode, size_word);
        end
    endtask

    function automatic logic [7:0] pick_bank(input logic [15:0] w);
        return (w[10:8] < 3'd6) ? banks[w[10:8]] : w[7:0];
    endfunction

    function automatic string tag_of(input logic [5:0] m, input logic [15:0] e0);
        case (m[5:3])
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5, 3'd6: return "R7";
            default: case (m[2:0])
                3'd0, 3'd1, 3'd2: return "R8";
                3'd3, 3'd4: return "R9";
                3'd5: return "R10";
                3'd6: return e0[15] ? "R11" : "R10";
                default: return "R2";
            endcase
        endcase
    endfunction

    // expected packing: {ea, kind, reg_sel, ext_count, wb_en, wb_reg, wb_data}
    function automatic logic [63:0] expect_of(input logic [5:0] m, input logic sz,
                                              input logic [15:0] e0, input logic [15:0] e1);
        logic [23:0] x_ea = '0;
        logic [1:0]  x_kind = 2'd0, x_n = 2'd0;
        logic [2:0]  x_sel = '0, x_wr = '0, r = m[2:0];
        logic        x_wb = 1'b0;
        logic [15:0] x_wd = '0, stp = sz ? 16'd2 : 16'd1, lo;
        logic [15:0] ix = regs[e0[12:10]] * (e0[9] ? 16'd2 : 16'd1) + {{7{e0[8]}}, e0[8:0]};
        case (m[5:3])
            3'd0: begin x_kind = 2'd1; x_sel = r; end
            3'd1: x_ea = {banks[r/2], regs[r]};
            3'd2: begin x_ea = {banks[r/2], regs[r]}; x_wb = 1; x_wr = r; x_wd = regs[r] + stp; end
            3'd3: begin lo = regs[r] - stp; x_ea = {banks[r/2], lo}; x_wb = 1; x_wr = r; x_wd = lo; end
            3'd4: begin lo = regs[r] + e0; x_ea = {banks[r/2], lo}; x_n = 1; end
            3'd5: begin x_ea = {pick_bank(e0), regs[r]}; x_n = 1; end
            3'd6: begin lo = regs[r] + e0; x_ea = {pick_bank(e1), lo}; x_n = 2; end
            default: begin
                x_n = 1;
                case (r)
                    3'd0: x_ea = {banks[5], e0};
                    3'd1: x_ea = {banks[4], e0};
                    3'd2: begin x_ea = {pick_bank(e1), e0}; x_n = 2; end
                    3'd3: begin lo = regs[e0[15:13]] + ix; x_ea = {banks[e0[15:13]/2], lo}; end
                    3'd4: begin lo = regs[e0[15:13]] + ix; x_ea = {pick_bank(e1), lo}; x_n = 2; end
                    3'd5: begin lo = pc + e0; x_ea = {banks[4], lo}; end
                    3'd6: if (e0[15]) begin x_kind = 2'd3; x_sel = e0[12:10]; end
                          else begin lo = pc + ix; x_ea = {banks[4], lo}; end
                    default: x_kind = 2'd2;
                endcase
            end
        endcase
        return {13'd0, x_ea, x_kind, x_sel, x_n, x_wb, x_wr, x_wd};
    endfunction

    function automatic logic [63:0] actual();
        return {13'd0, ea, kind, reg_sel, ext_count, wb_en, wb_reg, wb_data};
    endfunction

    // drive at a falling edge, result due after the next rising edge
    task automatic run_one(input logic [5:0] m, input logic sz, input logic [15:0] e0, input logic [15:0] e1);
        logic [63:0] exp;
        mode = m; size_word = sz; ext0 = e0; ext1 = e1; req_valid = 1'b1;
        load_state();
        exp = expect_of(m, sz, e0, e1);
        @(negedge clk);
        check("R1 valid", {63'd0, res_valid}, 64'd1);
        check(tag_of(m, e0), actual(), exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] held;
        for (int i = 0; i < 8; i++) regs[i] = 16'h1000 * i[15:0] + 16'h11;
        for (int i = 0; i < 6; i++) banks[i] = 8'hA0 + i[7:0];
        load_state();
        req_valid = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset", {63'd0, res_valid}, 64'd0);
        check("R1 reset", actual(), 64'd0);
        rst = 1'b0;

        // directed corners
        regs[1] = 16'hFFFF; banks[0] = 8'h12;
        run_one(6'o41, 1'b0, 16'h0002, 16'h0);              // R6 wrap, no carry into bank
        check("R6 wrap", {40'd0, ea}, 64'h120001);
        run_one(6'o21, 1'b1, 16'h0, 16'h0);                 // R4 wrap of write-back
        check("R4 wrap", {48'd0, wb_data}, 64'h0001);
        regs[1] = 16'h0000;
        run_one(6'o31, 1'b1, 16'h0, 16'h0);                 // R5 wrap below zero
        check("R5 wrap", {48'd0, wb_data}, 64'hFFFE);
        run_one(6'o52, 1'b0, 16'h07C3, 16'h0);              // R7 selector 7 -> literal
        check("R7 sel7", {56'd0, ea[23:16]}, 64'hC3);
        run_one(6'o76, 1'b0, 16'h93FF, 16'h0);              // R11 low fields ignored
        check("R11 ignore", {62'd0, kind}, 64'd3);
        check("R11 ignore", {61'd0, reg_sel}, 64'd4);

        // R1 hold: strobe low, inputs changed
        held = actual();
        req_valid = 1'b0; mode = 6'o77; ext0 = 16'h5555; regs[3] = 16'hBEEF; load_state();
        @(negedge clk);
        check("R1 hold", {63'd0, res_valid}, 64'd0);
        check("R1 hold", actual(), held);

        // sweep all modes, both sizes
        for (int m = 0; m < 64; m++) begin
            for (int sz = 0; sz < 2; sz++) begin
                for (int t = 0; t < 6; t++) begin
                    logic [15:0] e0, e1;
                    for (int i = 0; i < 8; i++) regs[i] = 16'($urandom);
                    for (int i = 0; i < 6; i++) banks[i] = 8'($urandom);
                    pc = 16'($urandom);
                    e0 = 16'($urandom);
                    e1 = 16'($urandom);
                    if (t < 2) e1[10:8] = 3'(t + 5);
                    if (t == 2) e0[15] = 1'b0;
                    if (t == 3) e0[15] = 1'b1;
                    if (t == 4) e0[8:0] = 9'h100;
                    run_one(6'(m), 1'(sz), e0, e1);
                end
            end
        end

        req_valid = 1'b0;
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule